// File: doc/BRIEF.md
# Packed Float-to-Integer Truncating Converter

This block takes a 128-bit vector of packed IEEE-754 floating-point values and turns it into four 32-bit integer lanes. Each value is rounded toward zero. A format input chooses between four single-precision elements and two double-precision elements. A signedness input chooses a signed or an unsigned integer target.

A policy input decides what happens to NaN and out-of-range values. In sentinel policy every invalid lane takes one fixed marker value. In saturating policy NaN becomes zero and a value that is too large clamps to the nearest bound. For finite inputs whose truncated value fits the target, both policies give the same result.

Inputs are offered with a valid flag and are always accepted. The converted vector is registered and shows up one cycle later with its own valid flag.

Top module: `vtc_trunc_conv`

## Requirements
- R1: `in_ready` is 1 at all times. An input presented with `in_valid`=1 produces `out_valid`=1 on the next clock cycle. `out_valid` is 0 after any cycle with `in_valid`=0, and `out_data` then holds its previous value.
- R2: With `fmt_dp`=0 and `is_unsigned`=0, lane i (bits 32i+31:32i) is treated as a single-precision float and is converted to the signed 32-bit integer nearest to it in the direction of zero.
- R3: With `fmt_dp`=0 and `is_unsigned`=1, each lane converts to an unsigned 32-bit integer by truncation. Inputs strictly between -1 and 0 give 0 and are not out of range.
- R4: With `fmt_dp`=1, the double at bits 63:0 converts into lane 0 and the double at bits 127:64 converts into lane 1. Lanes 2 and 3 (bits 127:64 of the output) are 0.
- R5: With `sat_mode`=0 and signed output, a lane that is NaN or out of the range -2^31..2^31-1 gives 0x80000000.
- R6: With `sat_mode`=0 and unsigned output, a lane that is NaN or out of the range 0..2^32-1 gives 0xFFFFFFFF.
- R7: With `sat_mode`=1, a NaN lane gives 0. An out-of-range lane clamps to the bound on its side: 0x7FFFFFFF or 0x80000000 when signed, 0xFFFFFFFF or 0 when unsigned.
- R8: Infinities are out of range and take the policy result for their sign. Zeros of either sign, subnormals and magnitudes below 1 convert to 0.
- R9: The range test is made on the truncated value. Exactly -2^31, and a double in (-2^31-1, -2^31], are accepted in signed mode. 2^31 is rejected in signed mode, 2^32 is rejected in unsigned mode, and a double in (2^32-1, 2^32) is accepted in unsigned mode.
- R10: While `rst_n` is low, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Block accepts input (always 1) |
| in_data | input | 128 | Packed floating-point vector |
| fmt_dp | input | 1 | 1: two doubles, 0: four singles |
| is_unsigned | input | 1 | 1: unsigned integer target, 0: signed |
| sat_mode | input | 1 | 1: saturating policy, 0: sentinel policy |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Four 32-bit integer lanes |

## Verification
Ordinary mixed-sign fractional values show that truncation goes toward zero rather than toward minus infinity, and that each lane is placed correctly. The values just inside and just outside each bound (±2^31, 2^32, -1) separate a range test done on the truncated value from one done on the raw value. The same NaN, infinity and overflow patterns are run under every policy and signedness pair, so a wrong marker or a wrong clamp direction is caught. Random vectors with exponents gathered near the integer range check both formats against a real-number truncation model.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int INT_W = 32;

  // Classification of one floating-point element after decoding
  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             huge;   // infinity or |x| >= 2^INT_W
    logic [INT_W-1:0] mag;    // truncated magnitude when not huge
  } lane_cls_t;
endpackage

// File: rtl/vtc_decode.sv
module vtc_decode
  import vtc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fp,
  output lane_cls_t            cls
);
  localparam int            FP_W    = EXP_W + MAN_W + 1;
  localparam int            BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int            SH_W    = $clog2(INT_W);
  localparam int            WIDE_W  = MAN_W + 1 + INT_W;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W:0]   EXP_LO   = (EXP_W+1)'(BIAS);
  localparam logic [EXP_W:0]   EXP_HI   = (EXP_W+1)'(BIAS + INT_W);

  logic             sgn;
  logic [EXP_W-1:0] bexp;
  logic [MAN_W-1:0] frac;
  logic [EXP_W:0]   bexp_x;
  logic [SH_W-1:0]  sh;
  logic [WIDE_W-1:0] wide;
  logic             below_one;

  always_comb begin
    sgn       = fp[FP_W-1];
    bexp      = fp[FP_W-2:MAN_W];
    frac      = fp[MAN_W-1:0];
    bexp_x    = {1'b0, bexp};
    below_one = (bexp_x < EXP_LO);
    sh        = SH_W'(bexp_x - EXP_LO);
    wide      = {{INT_W{1'b0}}, 1'b1, frac} << sh;

    cls.sign = sgn;
    cls.nan  = (bexp == EXP_ONES) && (frac != '0);
    cls.huge = (bexp == EXP_ONES) || (bexp_x >= EXP_HI);
    cls.mag  = below_one ? '0 : INT_W'(wide >> MAN_W);
  end
endmodule

// File: rtl/vtc_select.sv
module vtc_select
  import vtc_pkg::*;
(
  input  lane_cls_t        cls,
  input  logic             is_unsigned,
  input  logic             sat_mode,
  output logic [INT_W-1:0] res
);
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] U_MAX = '1;

  logic             fits;
  logic [INT_W-1:0] ok_val;
  logic [INT_W-1:0] bad_val;

  always_comb begin
    if (cls.nan || cls.huge)
      fits = 1'b0;
    else if (is_unsigned)
      fits = !cls.sign || (cls.mag == '0);
    else
      fits = cls.sign ? (cls.mag <= S_MIN) : !cls.mag[INT_W-1];

    ok_val = (cls.sign && !is_unsigned) ? (~cls.mag + 1'b1) : cls.mag;

    if (!sat_mode)
      bad_val = is_unsigned ? U_MAX : S_MIN;
    else if (cls.nan)
      bad_val = '0;
    else if (is_unsigned)
      bad_val = cls.sign ? '0 : U_MAX;
    else
      bad_val = cls.sign ? S_MIN : S_MAX;

    res = fits ? ok_val : bad_val;
  end
endmodule

// File: rtl/vtc_trunc_conv.sv
module vtc_trunc_conv
  import vtc_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  input  logic             fmt_dp,
  input  logic             is_unsigned,
  input  logic             sat_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  localparam int SP_W     = 32;
  localparam int DP_W     = 64;
  localparam int SP_LANES = VEC_W / SP_W;
  localparam int DP_LANES = VEC_W / DP_W;

  lane_cls_t        sp_cls  [SP_LANES];
  lane_cls_t        dp_cls  [DP_LANES];
  lane_cls_t        pick_cls[SP_LANES];
  logic [INT_W-1:0] lane_res[SP_LANES];
  logic [VEC_W-1:0] data_d;
  logic             valid_d;

  assign in_ready = 1'b1;

  for (genvar i = 0; i < SP_LANES; i++) begin : g_sp
    vtc_decode #(.EXP_W(8), .MAN_W(23)) u_dec (
      .fp  (in_data[i*SP_W +: SP_W]),
      .cls (sp_cls[i])
    );
  end

  for (genvar j = 0; j < DP_LANES; j++) begin : g_dp
    vtc_decode #(.EXP_W(11), .MAN_W(52)) u_dec (
      .fp  (in_data[j*DP_W +: DP_W]),
      .cls (dp_cls[j])
    );
  end

  for (genvar i = 0; i < SP_LANES; i++) begin : g_lane
    if (i < DP_LANES) begin : g_mix
      assign pick_cls[i] = fmt_dp ? dp_cls[i] : sp_cls[i];
    end else begin : g_spo
      assign pick_cls[i] = sp_cls[i];
    end

    vtc_select u_sel (
      .cls         (pick_cls[i]),
      .is_unsigned (is_unsigned),
      .sat_mode    (sat_mode),
      .res         (lane_res[i])
    );

    if (i < DP_LANES) begin : g_keep
      assign data_d[i*INT_W +: INT_W] = lane_res[i];
    end else begin : g_zero
      assign data_d[i*INT_W +: INT_W] = fmt_dp ? '0 : lane_res[i];
    end
  end

  assign valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_data <= '0;
    else if (in_valid)
      out_data <= data_d;
  end
endmodule

// File: rtl/vtc_trunc_conv_chk.sv
module vtc_trunc_conv_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] in_data,
  input logic             fmt_dp,
  input logic             is_unsigned,
  input logic             sat_mode,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data
);
  logic l0_sp_nan;
  assign l0_sp_nan = (in_data[30:23] == 8'hFF) && (in_data[22:0] != '0);

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R4
  dp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_dp) |=> (out_data[VEC_W-1:64] == '0));

  // R5
  sent_signed_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_dp && !sat_mode && !is_unsigned && l0_sp_nan)
      |=> (out_data[31:0] == 32'h8000_0000));

  // R6
  sent_unsigned_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_dp && !sat_mode && is_unsigned && l0_sp_nan)
      |=> (out_data[31:0] == 32'hFFFF_FFFF));

  // R7
  sat_nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_dp && sat_mode && l0_sp_nan) |=> (out_data[31:0] == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));
endmodule

bind vtc_trunc_conv vtc_trunc_conv_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vtc_trunc_conv_tb.sv
module vtc_trunc_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic         fmt_dp;
  logic         is_unsigned;
  logic         sat_mode;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtc_trunc_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fmt_dp(fmt_dp), .is_unsigned(is_unsigned),
    .sat_mode(sat_mode), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real pow2(int e);
    real r = 1.0;
    if (e >= 0) for (int k = 0; k < e; k++) r = r * 2.0;
    else        for (int k = 0; k < -e; k++) r = r / 2.0;
    return r;
  endfunction

  // value of a single-precision pattern; nan flagged separately
  function automatic real sp_val(logic [31:0] b, output bit nan);
    real v;
    nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (b[30:23] == 8'hFF)      v = 1.0e300;
    else if (b[30:23] == 8'h00) v = real'(b[22:0]) * pow2(-149);
    else v = (1.0 + real'(b[22:0]) * pow2(-23)) * pow2(int'(b[30:23]) - 127);
    return b[31] ? -v : v;
  endfunction

  function automatic logic [31:0] model(real v, bit nan, bit uns, bit sat);
    real    t;
    longint ti;
    if (nan) return sat ? 32'h0 : (uns ? 32'hFFFF_FFFF : 32'h8000_0000);
    t = (v >= 0.0) ? $floor(v) : -$floor(-v);
    if (uns) begin
      if (t > 4294967295.0) return 32'hFFFF_FFFF;
      if (t < 0.0)          return sat ? 32'h0 : 32'hFFFF_FFFF;
    end else begin
      if (t > 2147483647.0)  return sat ? 32'h7FFF_FFFF : 32'h8000_0000;
      if (t < -2147483648.0) return 32'h8000_0000;
    end
    ti = longint'(t);
    return ti[31:0];
  endfunction

  function automatic logic [127:0] expect_vec(logic [127:0] d, bit dp, bit uns, bit sat);
    logic [127:0] r = '0;
    bit nan;
    real v;
    if (dp) begin
      for (int j = 0; j < 2; j++) begin
        nan = (d[j*64+52 +: 11] == 11'h7FF) && (d[j*64 +: 52] != 0);
        v = nan ? 0.0 : $bitstoreal(d[j*64 +: 64]);
        r[j*32 +: 32] = model(v, nan, uns, sat);
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        v = sp_val(d[i*32 +: 32], nan);
        r[i*32 +: 32] = model(v, nan, uns, sat);
      end
    end
    return r;
  endfunction

  // drive one vector, check result and the hold that follows (R1)
  task automatic run_vec(string req, logic [127:0] d, bit dp, bit uns, bit sat);
    logic [127:0] exp_v;
    exp_v = expect_vec(d, dp, uns, sat);
    @(negedge clk);
    in_data = d; fmt_dp = dp; is_unsigned = uns; sat_mode = sat; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~d;
    check("R1 out_valid", {127'b0, out_valid}, 128'd1);
    check(req, out_data, exp_v);
    @(negedge clk);
    check("R1 hold", out_data, exp_v);
    check("R1 valid low", {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_reset;
    check("R10 valid", {127'b0, out_valid}, 128'd0);
    check("R10 data", out_data, 128'd0);
    check("R1 ready", {127'b0, in_ready}, 128'd1);
  endtask

  task automatic t_sp_signed;
    run_vec("R2", {32'h3FC00000, 32'hC0300000, 32'h42C9CCCD, 32'hBF000000}, 0, 0, 0);
    run_vec("R2", {32'h4EFFFFFF, 32'hC2C9CCCD, 32'h3F800000, 32'h40490FDB}, 0, 0, 1);
  endtask

  task automatic t_sp_unsigned;
    run_vec("R3", {32'hBF000000, 32'h4F32D05E, 32'h42C9CCCD, 32'hBF7FFFFF}, 0, 1, 0);
    run_vec("R3", {32'h3FC00000, 32'h4F7FFFFF, 32'h80000000, 32'hBE800000}, 0, 1, 1);
  endtask

  task automatic t_dp;
    run_vec("R4", {64'hC01F99999999999A, 64'h3FF8000000000000}, 1, 0, 0);
    run_vec("R4", {64'h41EFFFFFFFF00000, 64'h4059000000000000}, 1, 1, 1);
  endtask

  task automatic t_sentinel;
    run_vec("R5", {32'h7FC00000, 32'h4F000000, 32'hCF800000, 32'h3FC00000}, 0, 0, 0);
    run_vec("R6", {32'h7FC00000, 32'h4F800000, 32'hBF800000, 32'h3FC00000}, 0, 1, 0);
    run_vec("R5", {64'h7FF8000000000000, 64'hC1E0000000200000}, 1, 0, 0);
  endtask

  task automatic t_saturate;
    run_vec("R7", {32'h7FC00000, 32'h4F000000, 32'hCF800000, 32'h3FC00000}, 0, 0, 1);
    run_vec("R7", {32'h7FC00000, 32'h4F800000, 32'hBF800000, 32'h3FC00000}, 0, 1, 1);
    run_vec("R7", {64'h7FF8000000000000, 64'hC1E0000000200000}, 1, 0, 1);
  endtask

  task automatic t_special;
    for (int k = 0; k < 4; k++)
      run_vec("R8", {32'h7F800000, 32'hFF800000, 32'h80000000, 32'h00000001},
              0, k[0], k[1]);
  endtask

  task automatic t_bounds;
    run_vec("R9", {32'hCF000000, 32'h4F000000, 32'h4F800000, 32'hCF000001}, 0, 0, 1);
    run_vec("R9", {32'hCF000000, 32'h4F000000, 32'h4F800000, 32'h4F7FFFFF}, 0, 1, 0);
    run_vec("R9", {64'hC1E0000000100000, 64'hC1E0000000000000}, 1, 0, 0);
    run_vec("R9", {64'h41EFFFFFFFF00000, 64'h41F0000000000000}, 1, 1, 0);
  endtask

  task automatic t_random;
    logic [127:0] d;
    for (int n = 0; n < 60; n++) begin
      bit dp = n[0];
      for (int i = 0; i < 4; i++) begin
        d[i*32 +: 32] = $urandom;
        if (!dp) d[i*32+23 +: 8] = 8'(120 + ($urandom % 44));
      end
      if (dp) for (int j = 0; j < 2; j++) d[j*64+52 +: 11] = 11'(1016 + ($urandom % 40));
      run_vec(dp ? "R4 random" : "R2/R3 random", d, dp, n[1], n[2]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    fmt_dp = 1'b0; is_unsigned = 1'b0; sat_mode = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_sp_signed;
    t_sp_unsigned;
    t_dp;
    t_sentinel;
    t_saturate;
    t_special;
    t_bounds;
    t_random;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule